// File: doc/BRIEF.md
# Parallel DAC write sequencer

This block sits on the host side of a quad, double-buffered, parallel-input converter. It takes commands over a valid/ready port and turns each one into a strobe sequence on the converter's bus: a two-bit channel address, an eight-bit code, an active-low write strobe that loads a channel's input register, and an active-low load strobe that moves all input registers to the outputs at once. Every timing minimum (address and data setup before the write strobe rises, hold after it, write and load pulse widths) is given in picoseconds and turned into clock cycles at elaboration time.

A write command carries a channel, a code and a flag asking for a global load once the write is done. A separate load-all command pulses only the load strobe. With the immediate-update mode input held high, the load strobe stays low, so each output follows its write directly. The host can also queue several writes with the flag clear and then send one load-all command so that all outputs change together.

Top module: `dac_wr_seq`

## Requirements
- R1: While reset is asserted, and right after it, bus_wr_n and bus_ld_n are 1, cmd_ready is 1 and bus_addr and bus_data are 0; an assertion of reset in the middle of a command returns the outputs to these values at once.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1; cmd_ready is 0 from the cycle after acceptance until the last cycle of the command's sequence, and is 1 again in the cycle after.
- R3: For a write command (cmd_kind = 0), bus_addr and bus_data show the command's channel and code from the first cycle after acceptance, one full cycle before bus_wr_n falls, and stay unchanged through the hold cycle that follows the rise of bus_wr_n.
- R4: bus_wr_n is low for exactly WR_CYC consecutive cycles per write, WR_CYC being the largest of 1, ceil(T_WR_PS/CLK_PS), ceil(T_DS_PS/CLK_PS)-1 and ceil(T_AS_PS/CLK_PS)-1; the hold phase after it lasts 1 + ceil(max(T_AH_PS,T_DH_PS)/CLK_PS) cycles.
- R5: A write with cmd_load = 1 is followed, in the cycle after its hold phase, by a bus_ld_n low pulse of LD_CYC = max(1, ceil(T_LD_PS/CLK_PS)) cycles; bus_ld_n never falls while bus_wr_n is low.
- R6: A load-all command (cmd_kind = 1) drives bus_ld_n low for LD_CYC cycles starting the cycle after acceptance, keeps bus_wr_n at 1 and leaves bus_addr and bus_data unchanged.
- R7: imm_mode is sampled on every clock edge at which the block is idle (including the accepting edge); while the sampled value is 1, bus_ld_n is held at 0 throughout, and changes of imm_mode during a command take effect only after it ends.
- R8: Changes on cmd_chan, cmd_code, cmd_load and cmd_kind while a command is in progress have no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_mode | input | 1 | 1: hold the load strobe low so outputs follow writes |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_kind | input | 1 | 0: channel write, 1: load all channels |
| cmd_chan | input | CH_W | Channel to write |
| cmd_code | input | CODE_W | Code to write |
| cmd_load | input | 1 | Pulse a global load after this write |
| bus_addr | output | CH_W | Converter address lines |
| bus_data | output | CODE_W | Converter data lines |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ld_n | output | 1 | Active-low load strobe |

## Verification
The hardest situations to reach are a change of immediate-update mode while a command is running and a reset landing in the middle of a write strobe. The bench flips imm_mode and scrambles every command field in the first cycle of each sequence, then checks every following cycle against the mode and values captured at acceptance. It is built with timing values that make the write and load pulses several cycles long, so an off-by-one in any phase length shows at the ports, and a directed test drops reset while bus_wr_n is low.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_LOAD
  } dws_state_e;

  function automatic int cyc_ceil(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dws_timer.sv
module dws_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dws_bus_reg.sv
module dws_bus_reg #(
  parameter int CH_W   = 2,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [CH_W-1:0]   chan_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [CH_W-1:0]   addr_q,
  output logic [CODE_W-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= chan_in;
      data_q <= code_in;
    end
  end

endmodule

// File: rtl/dws_fsm.sv
module dws_fsm
  import dws_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int SU_CYC   = 1,
  parameter int WR_CYC   = 1,
  parameter int HOLD_CYC = 1,
  parameter int LD_CYC   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_kind,
  input  logic             cmd_load,
  input  logic             imm_mode,
  input  logic             tmr_zero,
  output logic             cmd_ready,
  output logic             cap_en,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             wr_n,
  output logic             ld_n
);

  dws_state_e state_q, state_d;
  logic       load_q, load_d;
  logic       imm_q, imm_d;

  always_comb begin
    state_d  = state_q;
    load_d   = load_q;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    imm_d    = (state_q == ST_IDLE) ? imm_mode : imm_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          tmr_load = 1'b1;
          if (cmd_kind) begin
            state_d = ST_LOAD;
            tmr_val = CNT_W'(LD_CYC - 1);
          end else begin
            state_d = ST_SETUP;
            cap_en  = 1'b1;
            load_d  = cmd_load;
            tmr_val = CNT_W'(SU_CYC - 1);
          end
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WR_CYC - 1);
        end
      end
      ST_STROBE: begin
        if (tmr_zero) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          if (load_q) begin
            state_d  = ST_LOAD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(LD_CYC - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_LOAD: begin
        if (tmr_zero) begin
          state_d = ST_IDLE;
          load_d  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      load_q  <= 1'b0;
      imm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= load_d;
      imm_q   <= imm_d;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign wr_n      = (state_q != ST_STROBE);
  assign ld_n      = !(imm_q || (state_q == ST_LOAD));

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dws_pkg::*;
#(
  parameter int CH_W    = 2,
  parameter int CODE_W  = 8,
  parameter int CLK_PS  = 20000,
  parameter int T_AS_PS = 5000,
  parameter int T_AH_PS = 0,
  parameter int T_DS_PS = 25000,
  parameter int T_DH_PS = 0,
  parameter int T_WR_PS = 20000,
  parameter int T_LD_PS = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              imm_mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_kind,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_load,
  output logic [CH_W-1:0]   bus_addr,
  output logic [CODE_W-1:0] bus_data,
  output logic              bus_wr_n,
  output logic              bus_ld_n
);

  localparam int SU_CYC   = 1;
  localparam int WR_CYC   = imax(imax(1, cyc_ceil(T_WR_PS, CLK_PS)),
                                 imax(cyc_ceil(T_DS_PS, CLK_PS) - SU_CYC,
                                      cyc_ceil(T_AS_PS, CLK_PS) - SU_CYC));
  localparam int HOLD_CYC = 1 + cyc_ceil(imax(T_AH_PS, T_DH_PS), CLK_PS);
  localparam int LD_CYC   = imax(1, cyc_ceil(T_LD_PS, CLK_PS));
  localparam int MAX_CYC  = imax(imax(WR_CYC, HOLD_CYC), imax(LD_CYC, SU_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             cap_en;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  dws_fsm #(
    .CNT_W   (CNT_W),
    .SU_CYC  (SU_CYC),
    .WR_CYC  (WR_CYC),
    .HOLD_CYC(HOLD_CYC),
    .LD_CYC  (LD_CYC)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_load (cmd_load),
    .imm_mode (imm_mode),
    .tmr_zero (tmr_zero),
    .cmd_ready(cmd_ready),
    .cap_en   (cap_en),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .wr_n     (bus_wr_n),
    .ld_n     (bus_ld_n)
  );

  dws_timer #(.CNT_W(CNT_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  dws_bus_reg #(.CH_W(CH_W), .CODE_W(CODE_W)) i_bus (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap_en (cap_en),
    .chan_in(cmd_chan),
    .code_in(cmd_code),
    .addr_q (bus_addr),
    .data_q (bus_data)
  );

endmodule

// File: rtl/dws_chk.sv
module dws_chk #(
  parameter int CH_W   = 2,
  parameter int CODE_W = 8,
  parameter int WR_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic [CH_W-1:0]   bus_addr,
  input logic [CODE_W-1:0] bus_data,
  input logic              bus_wr_n,
  input logic              bus_ld_n
);

  logic [15:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
    end else if (!bus_wr_n) begin
      low_run_q <= low_run_q + 16'd1;
    end else begin
      low_run_q <= '0;
    end
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> bus_wr_n); // R2

  AST_BUS_STABLE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |=> $stable(bus_addr) && $stable(bus_data)); // R3

  AST_SETUP_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $stable(bus_addr) && $stable(bus_data)); // R3

  AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> $stable(bus_addr) && $stable(bus_data)); // R3

  AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (low_run_q == 16'(WR_CYC))); // R4

  AST_LD_FALL_OUTSIDE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ld_n) |-> bus_wr_n); // R5

endmodule

bind dac_wr_seq dws_chk #(
  .CH_W  (CH_W),
  .CODE_W(CODE_W),
  .WR_CYC(WR_CYC)
) i_dws_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_ready(cmd_ready),
  .bus_addr (bus_addr),
  .bus_data (bus_data),
  .bus_wr_n (bus_wr_n),
  .bus_ld_n (bus_ld_n)
);

// File: tb/test_dac_wr_seq.sv
module test_dac_wr_seq;

  // Timing chosen so phases span several 20 ns cycles:
  // write: max(1, ceil(30/20)=2, ceil(65/20)-1=3, ceil(5/20)-1=0) = 3
  // load : ceil(50/20) = 3, hold: 1 + ceil(0) = 1
  localparam int E_WR   = 3;
  localparam int E_LD   = 3;
  localparam int E_HOLD = 1;

  // {kind, load, imm, chan[1:0], code[7:0]}
  localparam logic [12:0] VEC [8] = '{
    13'b0_0_0_00_01011010,
    13'b0_1_0_11_11111111,
    13'b1_0_0_00_00000000,
    13'b0_0_1_01_00000000,
    13'b0_1_1_10_10000001,
    13'b1_0_1_00_00000000,
    13'b0_1_0_01_11000011,
    13'b0_0_0_10_00111100
  };

  logic       clk;
  logic       rst_n;
  logic       imm_mode;
  logic       cmd_valid;
  logic       cmd_ready;
  logic       cmd_kind;
  logic [1:0] cmd_chan;
  logic [7:0] cmd_code;
  logic       cmd_load;
  logic [1:0] bus_addr;
  logic [7:0] bus_data;
  logic       bus_wr_n;
  logic       bus_ld_n;

  int checks;
  int errors;
  bit done;
  logic [1:0] exp_a;
  logic [7:0] exp_d;

  dac_wr_seq #(
    .CLK_PS (20000),
    .T_AS_PS(5000),
    .T_DS_PS(65000),
    .T_WR_PS(30000),
    .T_LD_PS(50000)
  ) i_dac_wr_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .imm_mode (imm_mode),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_kind (cmd_kind),
    .cmd_chan (cmd_chan),
    .cmd_code (cmd_code),
    .cmd_load (cmd_load),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .bus_wr_n (bus_wr_n),
    .bus_ld_n (bus_ld_n)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reset_state_chk(input string tag);
    chk({tag, " wr_n"}, int'(bus_wr_n), 1);
    chk({tag, " ld_n"}, int'(bus_ld_n), 1);
    chk({tag, " ready"}, int'(cmd_ready), 1);
    chk({tag, " addr"}, int'(bus_addr), 0);
    chk({tag, " data"}, int'(bus_data), 0);
  endtask

  task automatic do_cmd(input logic kind, input logic ld, input logic imm,
                        input logic [1:0] ch, input logic [7:0] cd);
    int total;
    bit exp_wr;
    bit exp_ld;
    @(negedge clk);
    chk("R2 ready before", int'(cmd_ready), 1);
    cmd_valid = 1'b1;
    cmd_kind  = kind;
    cmd_load  = ld;
    cmd_chan  = ch;
    cmd_code  = cd;
    imm_mode  = imm;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_kind  = ~kind;
    cmd_load  = ~ld;
    cmd_chan  = ~ch;
    cmd_code  = ~cd;
    imm_mode  = ~imm;
    if (!kind) begin
      exp_a = ch;
      exp_d = cd;
      total = 1 + E_WR + E_HOLD + (ld ? E_LD : 0);
    end else begin
      total = E_LD;
    end
    for (int i = 0; i < total; i++) begin
      exp_wr = kind ? 1'b1 : !((i >= 1) && (i <= E_WR));
      exp_ld = kind ? 1'b0 : !(imm || (i >= 1 + E_WR + E_HOLD));
      chk(kind ? "R6 wr_n" : "R4 wr_n", int'(bus_wr_n), int'(exp_wr));
      chk(imm ? "R7 ld_n" : (kind ? "R6 ld_n" : "R5 ld_n"),
          int'(bus_ld_n), int'(exp_ld));
      chk("R2 ready busy", int'(cmd_ready), 0);
      chk("R3 addr", int'(bus_addr), int'(exp_a));
      chk("R8 data", int'(bus_data), int'(exp_d));
      @(negedge clk);
    end
    chk("R2 ready after", int'(cmd_ready), 1);
    chk("R4 wr_n idle", int'(bus_wr_n), 1);
    chk("R7 ld_n idle", int'(bus_ld_n), imm ? 0 : 1);
    imm_mode = imm;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    exp_a     = '0;
    exp_d     = '0;
    rst_n     = 1'b0;
    imm_mode  = 1'b0;
    cmd_valid = 1'b0;
    cmd_kind  = 1'b0;
    cmd_chan  = '0;
    cmd_code  = '0;
    cmd_load  = 1'b0;
    repeat (3) @(negedge clk);
    reset_state_chk("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_state_chk("R1 after reset");

    for (int v = 0; v < 8; v++) begin
      do_cmd(VEC[v][12], VEC[v][11], VEC[v][10], VEC[v][9:8], VEC[v][7:0]);
    end

    // R7: mode follows imm_mode while idle, one edge later
    @(negedge clk);
    imm_mode = 1'b1;
    @(negedge clk);
    chk("R7 idle imm on", int'(bus_ld_n), 0);
    imm_mode = 1'b0;
    @(negedge clk);
    chk("R7 idle imm off", int'(bus_ld_n), 1);

    // R1: reset while the write strobe is low
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_kind  = 1'b0;
    cmd_load  = 1'b1;
    cmd_chan  = 2'd3;
    cmd_code  = 8'hA5;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R4 wr_n low before reset", int'(bus_wr_n), 0);
    rst_n = 1'b0;
    #1ns;
    reset_state_chk("R1 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_state_chk("R1 after mid reset");
    exp_a = '0;
    exp_d = '0;
    do_cmd(1'b0, 1'b0, 1'b0, 2'd2, 8'h77);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule